// File: doc/BRIEF.md
# Fault-Routing Lock and Erase-Status Register Bank

This block is a small bank of protection registers on a simple register bus. The first register holds four lock bits. Software can set each one, but no write can clear it. A set lock connects one fault source to a pair of timer break outputs. The four sources are the CPU lockup signal, an SRAM parity error, a supply-voltage detector interrupt and an ECC double-error flag. The voltage-detector lock also drives an output that tells the power controller to treat its detector enable and 3-bit level fields as read-only.

The second register holds two erase-done flags. The erase engine sets a flag with a one-cycle pulse, and software clears it by writing 1. The block has two separate reset inputs. Power-on reset clears everything. System reset clears the locks and the tamper-erase flag, but the full-erase flag survives it.

The bus is plain. A write takes effect on the clock edge where `bus_wr` is high. `bus_rdata` is combinational from `bus_addr`. The block applies no back-pressure.

Top module: `fault_guard_regs`

## Requirements
- R1: The lock register is at byte offset 0x0. Writing 1 to a bit sets that lock on the next clock edge. The bits are CPU lockup at bit 0, SRAM parity at bit 1, voltage detector at bit 2 and ECC double error at bit 3. Bits 31:4 always read 0.
- R2: Writing 0 never clears a set lock, and later writes OR into the locks already set. Only a system reset or a power-on reset returns the locks to 0.
- R3: Each `brk_out` bit is registered and goes high one cycle after any fault source whose lock is set is high. The `fault_src` bits use the same positions as the lock bits. Sources whose lock is clear have no effect. Both outputs always carry the same value.
- R4: `vdet_cfg_ro` equals the voltage-detector lock (bit 2) and stays high once it is set, until a reset.
- R5: The status register is at byte offset 0x4. A pulse on `erase_full_done` sets bit 0, and a pulse on `erase_tamper_done` sets bit 16. All other bits read 0.
- R6: Writing 1 to bit 0 or bit 16 of the status register clears that flag. Writing 0 to a flag leaves it unchanged.
- R7: If a set pulse and a write-1-to-clear hit the same flag in the same cycle, the flag ends up set.
- R8: System reset clears status bit 16 and leaves status bit 0 unchanged.
- R9: Power-on reset clears every lock, both status flags and both break outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_sys_n | input | 1 | System reset, active low, asynchronous |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| fault_src | input | 4 | Fault sources: bit 3 ECC, bit 2 voltage detector, bit 1 parity, bit 0 lockup |
| erase_full_done | input | 1 | Pulse: full memory erase has completed |
| erase_tamper_done | input | 1 | Pulse: cache and crypto-RAM erase has completed |
| brk_out | output | 2 | Timer break outputs |
| vdet_cfg_ro | output | 1 | Voltage-detector configuration is read-only |

## Verification
The assertions assume that both reset inputs are released synchronously and that the erase-done inputs and the write strobe are clean single-cycle, clock-aligned levels. They assume nothing about the fault sources, so a fault may be present even while no lock is set. The bench changes every input on the falling edge and pulses the resets only between test phases. Each lock pattern is swept against every fault pattern after a fresh system reset, because a lock can only be cleared by reset.

// File: rtl/fgr_pkg.sv
package fgr_pkg;
  localparam int LOCK_N       = 4;
  localparam int LK_LOCKUP    = 0;
  localparam int LK_PARITY    = 1;
  localparam int LK_VDET      = 2;
  localparam int LK_ECC       = 3;
  localparam int ST_FULL_BIT  = 0;
  localparam int ST_TAMP_BIT  = 16;
endpackage

// File: rtl/fgr_lock_bank.sv
module fgr_lock_bank #(
  parameter int LOCK_N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LOCK_N-1:0] wr_bits,
  output logic [LOCK_N-1:0] lock_q
);
  // Set-only: a write ORs new bits in, nothing but reset clears them.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lock_q <= '0;
    else if (wr_en) lock_q <= lock_q | wr_bits;
  end

  p_lock_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(lock_q) & ~lock_q) == '0));
endmodule

// File: rtl/fgr_break_route.sv
module fgr_break_route #(
  parameter int LOCK_N  = 4,
  parameter int BREAK_N = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LOCK_N-1:0]  lock,
  input  logic [LOCK_N-1:0]  fault,
  output logic [BREAK_N-1:0] brk_q
);
  logic hit;
  assign hit = |(lock & fault);

  for (genvar k = 0; k < BREAK_N; k++) begin : g_brk
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) brk_q[k] <= 1'b0;
      else        brk_q[k] <= hit;
    end
  end

  p_brk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lock) == '0) |-> (brk_q == '0));
  p_brk_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_q == '0) || (brk_q == '1));
endmodule

// File: rtl/fgr_erase_status.sv
module fgr_erase_status (
  input  logic clk,
  input  logic rst_por_n,
  input  logic rst_any_n,
  input  logic wr_en,
  input  logic clr_full,
  input  logic clr_tamp,
  input  logic set_full,
  input  logic set_tamp,
  output logic full_q,
  output logic tamp_q
);
  logic kill_full, kill_tamp;
  assign kill_full = wr_en & clr_full;
  assign kill_tamp = wr_en & clr_tamp;

  // Power-on domain only: survives system reset.
  always_ff @(posedge clk or negedge rst_por_n) begin
    if (!rst_por_n)     full_q <= 1'b0;
    else if (set_full)  full_q <= 1'b1;
    else if (kill_full) full_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_any_n) begin
    if (!rst_any_n)     tamp_q <= 1'b0;
    else if (set_tamp)  tamp_q <= 1'b1;
    else if (kill_tamp) tamp_q <= 1'b0;
  end

  p_full_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_por_n)
    set_full |=> full_q);
  p_tamp_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_any_n)
    set_tamp |=> tamp_q);
  p_full_hold_r8: assert property (@(posedge clk) disable iff (!rst_por_n)
    ($past(full_q) && !$past(kill_full)) |-> full_q);
  p_full_rise_r5: assert property (@(posedge clk) disable iff (!rst_por_n)
    $rose(full_q) |-> $past(set_full));
endmodule

// File: rtl/fault_guard_regs.sv
module fault_guard_regs
  import fgr_pkg::*;
#(
  parameter int            DATA_W   = 32,
  parameter int            ADDR_W   = 4,
  parameter int            BREAK_N  = 2,
  parameter logic [3:0]    LOCK_OFS = 4'h0,
  parameter logic [3:0]    STAT_OFS = 4'h4
) (
  input  logic               clk,
  input  logic               rst_por_n,
  input  logic               rst_sys_n,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [LOCK_N-1:0]  fault_src,
  input  logic               erase_full_done,
  input  logic               erase_tamper_done,
  output logic [BREAK_N-1:0] brk_out,
  output logic               vdet_cfg_ro
);
  logic              rst_any_n;
  logic              wr_lock, wr_stat;
  logic [LOCK_N-1:0] lock_q;
  logic              full_q, tamp_q;
  logic              unused_wd;

  assign rst_any_n = rst_por_n & rst_sys_n;
  assign wr_lock   = bus_wr && (bus_addr == ADDR_W'(LOCK_OFS));
  assign wr_stat   = bus_wr && (bus_addr == ADDR_W'(STAT_OFS));
  assign unused_wd = ^bus_wdata;

  fgr_lock_bank #(.LOCK_N(LOCK_N)) u_lock (
    .clk(clk), .rst_n(rst_any_n), .wr_en(wr_lock),
    .wr_bits(bus_wdata[LOCK_N-1:0]), .lock_q(lock_q));

  fgr_break_route #(.LOCK_N(LOCK_N), .BREAK_N(BREAK_N)) u_route (
    .clk(clk), .rst_n(rst_any_n), .lock(lock_q), .fault(fault_src),
    .brk_q(brk_out));

  fgr_erase_status u_stat (
    .clk(clk), .rst_por_n(rst_por_n), .rst_any_n(rst_any_n),
    .wr_en(wr_stat), .clr_full(bus_wdata[ST_FULL_BIT]),
    .clr_tamp(bus_wdata[ST_TAMP_BIT]), .set_full(erase_full_done),
    .set_tamp(erase_tamper_done), .full_q(full_q), .tamp_q(tamp_q));

  assign vdet_cfg_ro = lock_q[LK_VDET];

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(LOCK_OFS)) begin
      bus_rdata[LOCK_N-1:0] = lock_q;
    end else if (bus_addr == ADDR_W'(STAT_OFS)) begin
      bus_rdata[ST_FULL_BIT] = full_q;
      bus_rdata[ST_TAMP_BIT] = tamp_q;
    end
  end

  p_vdet_sticky_r4: assert property (@(posedge clk) disable iff (!rst_any_n)
    vdet_cfg_ro |=> vdet_cfg_ro);
  p_lock_needs_write_r1: assert property (@(posedge clk) disable iff (!rst_any_n)
    ($past(lock_q) != lock_q) |-> $past(wr_lock));
endmodule

// File: tb/test_fault_guard_regs.sv
module test_fault_guard_regs;
  logic        clk = 1'b0;
  logic        rst_por_n = 1'b0, rst_sys_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  fault_src = '0;
  logic        erase_full_done = 1'b0, erase_tamper_done = 1'b0;
  logic [1:0]  brk_out;
  logic        vdet_cfg_ro;
  int          checks = 0, failures = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  fault_guard_regs i_fault_guard_regs (
    .clk(clk), .rst_por_n(rst_por_n), .rst_sys_n(rst_sys_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .fault_src(fault_src),
    .erase_full_done(erase_full_done), .erase_tamper_done(erase_tamper_done),
    .brk_out(brk_out), .vdet_cfg_ro(vdet_cfg_ro));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic sys_reset();
    @(negedge clk); rst_sys_n = 1'b0;
    @(negedge clk); rst_sys_n = 1'b1;
  endtask

  task automatic por_reset();
    @(negedge clk); rst_por_n = 1'b0;
    @(negedge clk); rst_por_n = 1'b1;
  endtask

  task automatic pulse(input bit full, input bit tamp);
    @(negedge clk); erase_full_done = full; erase_tamper_done = tamp;
    @(negedge clk); erase_full_done = 1'b0; erase_tamper_done = 1'b0;
  endtask

  initial begin
    logic [31:0] r;
    repeat (2) @(negedge clk);
    rst_por_n = 1'b1; rst_sys_n = 1'b1;
    rd(4'h0, r); check("R9 lock after por", r, 0);
    rd(4'h4, r); check("R9 status after por", r, 0);
    check("R9 brk after por", {30'd0, brk_out}, 0);
    check("R4 vdet after por", {31'd0, vdet_cfg_ro}, 0);

    // Exhaustive lock x fault sweep
    for (int p = 0; p < 16; p++) begin
      sys_reset();
      wr(4'h0, 32'(p));
      rd(4'h0, r); check("R1 lock readback", r, 32'(p));
      check("R4 vdet follows lock bit 2", {31'd0, vdet_cfg_ro}, {31'd0, p[2]});
      wr(4'h0, 32'h0);
      rd(4'h0, r); check("R2 write 0 keeps locks", r, 32'(p));
      for (int f = 0; f < 16; f++) begin
        @(negedge clk); fault_src = 4'(f);
        @(negedge clk);
        check("R3 break routing", {30'd0, brk_out},
              ((p & f) != 0) ? 32'd3 : 32'd0);
      end
      @(negedge clk); fault_src = '0;
    end

    sys_reset();
    rd(4'h0, r); check("R2 sys reset clears locks", r, 0);
    wr(4'h0, 32'h1); wr(4'h0, 32'h8);
    rd(4'h0, r); check("R2 locks accumulate", r, 32'h9);
    wr(4'h0, 32'hFFFF_FFF0);
    rd(4'h0, r); check("R1 upper bits read 0", r, 32'h9);
    wr(4'h4, 32'h0001_0001);
    rd(4'h0, r); check("R1 status write leaves locks", r, 32'h9);

    // Erase status
    sys_reset();
    pulse(1, 0); rd(4'h4, r); check("R5 full erase set", r, 32'h1);
    pulse(0, 1); rd(4'h4, r); check("R5 tamper erase set", r, 32'h0001_0001);
    wr(4'h4, 32'h0);          rd(4'h4, r); check("R6 write 0 ignored", r, 32'h0001_0001);
    wr(4'h4, 32'h1);          rd(4'h4, r); check("R6 clear bit 0", r, 32'h0001_0000);
    wr(4'h4, 32'h0001_0000);  rd(4'h4, r); check("R6 clear bit 16", r, 32'h0);
    pulse(1, 1);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 4'h4; bus_wdata = 32'h0001_0001;
    erase_full_done = 1'b1; erase_tamper_done = 1'b1;
    @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
    erase_full_done = 1'b0; erase_tamper_done = 1'b0;
    rd(4'h4, r); check("R7 set wins over clear", r, 32'h0001_0001);
    sys_reset();
    rd(4'h4, r); check("R8 sys reset keeps bit 0 only", r, 32'h1);
    wr(4'h0, 32'hF);
    por_reset();
    rd(4'h4, r); check("R9 por clears status", r, 32'h0);
    rd(4'h0, r); check("R9 por clears locks", r, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule